// File: doc/BRIEF.md
# I2C Bus Wedge Fault Injector

This block is an I2C master used only for fault injection. It runs part of a transaction on the bus and then stops on purpose, leaving SCL released high and no stop condition on the bus. Attached targets are left in the middle of a transfer, so that their bus-recovery logic can be tested. A single command picks one of three hang points: the address acknowledge, the middle of a data read that follows a register select, or the middle of a register write. The command also carries a 7-bit target address, a register byte and a bit count.

Once the chosen hang point is reached, the block releases both lines and waits for SCL to read high. This wait uses the same clock-stretch limit as every other SCL wait in the transfer. The block then reports the SDA and SCL levels it sampled, together with a one-cycle done pulse. It stays parked, with neither line driven, until an explicit unpark input returns it to idle.

The bus pins are open drain. An output enable that is high pulls its line low, and an enable that is low releases the line. The line inputs pass through a synchronizer before the block uses them.

Top module: `i2c_wedge_gen`

## Requirements
- R1: The block accepts a command only in idle, on a cycle with `cmd_valid` high and `cmd_mode` equal to 1 (address-ACK hang), 2 (read hang) or 3 (write hang). `busy` is high from the cycle after acceptance until the done pulse. Mode 0 is ignored and leaves `busy` low.
- R2: The address-ACK hang sends a start and then the 7 address bits, MSB first, followed by a 0 (write) bit. It does not clock the acknowledge slot and then parks.
- R3: The read hang sends a start, the address with a 0 direction bit, one released ACK slot, the register byte MSB first, and one released ACK slot. It then sends a repeated start, the address with a 1 direction bit, and one released ACK slot. After that it clocks N data bits with SDA released and parks.
- R4: The write hang sends a start, the address with a 0 direction bit, and one released ACK slot. It then sends the top N bits of the register byte MSB first and parks, releasing SDA as though a 1 followed.
- R5: The bit count N is taken from `cmd_bits`. A value above 8 acts as 8, and 0 is allowed (no data bits).
- R6: On parking, both lines are released and the block waits for SCL to read high. It then raises `done` for exactly one cycle, with `busy` low and with `sda_level` and `scl_level` holding the sampled line levels.
- R7: If SCL stays low for STRETCH_MAX cycles during any SCL wait, the block goes on anyway. When that happens, `stretch_timeout` is 1 at the done pulse, and a park that timed out reports `scl_level` 0.
- R8: No stop condition (SDA rising while SCL is high) is ever produced.
- R9: The parked state holds, and new commands are ignored, until `unpark` is pulsed. After that the block is idle and a new command is accepted.
- R10: After reset, and at all times while `busy` is low, both `scl_oe` and `sda_oe` are low (lines released). The outputs `busy` and `done` reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_mode | input | 2 | Hang point: 1 address ACK, 2 read, 3 write, 0 ignored |
| cmd_addr | input | 7 | Target address |
| cmd_reg | input | 8 | Register byte |
| cmd_bits | input | 4 | Data bit count, clamped to 8 |
| unpark | input | 1 | Leave the parked state |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse when parked |
| sda_level | output | 1 | SDA level sampled at park |
| scl_level | output | 1 | SCL level sampled at park |
| stretch_timeout | output | 1 | An SCL wait in this transaction timed out |

## Verification
`busy` is due at the first falling edge after the rising edge that accepts the command, and the bench samples it exactly there. The done pulse is due SYNC_STAGES+1 falling edges after SCL reads high on the wire. The bench samples `done` at every falling edge in that window, and reads `busy`, the levels and the timeout flag in the same cycle as `done`. The bench logs the bus at every falling edge as starts, stops and bits (taken when SCL falls) and compares the log with a sequence built from R2 to R5. For the timeout case, it also checks that done comes no earlier than STRETCH_MAX cycles after it starts holding SCL low.

// File: rtl/i2cw_pkg.sv
// Shared types for the wedge fault injector.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package i2cw_pkg;

    // Hang point selected by a command; NONE is ignored.
    typedef enum logic [1:0] {
        MODE_NONE  = 2'd0,
        MODE_ACK   = 2'd1,
        MODE_READ  = 2'd2,
        MODE_WRITE = 2'd3
    } wedge_mode_e;

    // Bus-level operation executed by the bit engine.
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_TX    = 2'd1,
        OP_RX    = 2'd2,
        OP_PARK  = 2'd3
    } line_op_e;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 7;
    localparam int CNT_W     = 4;
    localparam int BITS_MAX  = 8;
    localparam int SEG_SLOTS = 10;
    localparam int SEG_IDX_W = $clog2(SEG_SLOTS);

    // One step of a hang script: an operation repeated count times.
    typedef struct packed {
        line_op_e          kind;
        logic [BYTE_W-1:0] data;
        logic [CNT_W-1:0]  count;
    } seg_t;

endpackage

// File: rtl/i2cw_line_sync.sv
// Synchronizes the sensed SCL and SDA levels into the clock domain.
// Assumes: STAGES >= 1; idle bus reads high, so stages reset to 1.
module i2cw_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s
);

    logic [STAGES-1:0] scl_p;
    logic [STAGES-1:0] sda_p;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage samples the pins.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_p[0] <= 1'b1;
                    sda_p[0] <= 1'b1;
                end else begin
                    scl_p[0] <= scl_i;
                    sda_p[0] <= sda_i;
                end
            end
        end else begin : g_next
            // Later stages copy the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_p[g] <= 1'b1;
                    sda_p[g] <= 1'b1;
                end else begin
                    scl_p[g] <= scl_p[g-1];
                    sda_p[g] <= sda_p[g-1];
                end
            end
        end
    end

    assign scl_s = scl_p[STAGES-1];
    assign sda_s = sda_p[STAGES-1];

endmodule

// File: rtl/i2cw_bit_engine.sv
// Executes one bus operation at a time: start, send bit, clock-in bit, park.
// Each operation sets SDA, waits DELAY cycles, releases SCL, waits for SCL
// high (bounded by STRETCH_MAX), holds DELAY cycles, then pulls SCL low;
// a start additionally drops SDA while SCL is high. Park stops after the
// SCL wait with both lines released.
// Assumes: op_valid only while ready; DELAY >= 1; STRETCH_MAX >= 1.
module i2cw_bit_engine
    import i2cw_pkg::*;
#(
    parameter int DELAY       = 8,
    parameter int STRETCH_MAX = 5000
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     op_valid,
    input  line_op_e op_kind,
    input  logic     op_bit,
    input  logic     scl_s,
    input  logic     sda_s,
    output logic     ready,
    output logic     op_done,
    output logic     park_done,
    output logic     stretch_expired,
    output logic     scl_low,
    output logic     sda_low
);

    localparam int DW = $clog2(DELAY + 1);
    localparam int SW = $clog2(STRETCH_MAX + 1);

    typedef enum logic [2:0] {
        E_IDLE, E_SETUP, E_STRETCH, E_HOLD, E_SDALOW
    } eng_st_e;

    eng_st_e  st;
    line_op_e kind_q;
    logic [DW-1:0] dly_cnt;
    logic [SW-1:0] str_cnt;
    logic dly_end;
    logic str_last;
    logic stretch_end;

    // Decode the end of delay and stretch windows and the completion events.
    always_comb begin
        dly_end         = (dly_cnt == DW'(DELAY - 1));
        str_last        = (str_cnt == SW'(STRETCH_MAX - 1));
        stretch_end     = (st == E_STRETCH) && (scl_s || str_last);
        stretch_expired = (st == E_STRETCH) && !scl_s && str_last;
        park_done       = stretch_end && (kind_q == OP_PARK);
        op_done         = park_done
                        || ((st == E_HOLD) && dly_end && (kind_q != OP_START))
                        || ((st == E_SDALOW) && dly_end);
        ready           = (st == E_IDLE);
    end

    // Operation sequencing and the two open-drain line drives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= E_IDLE;
            kind_q  <= OP_START;
            dly_cnt <= '0;
            str_cnt <= '0;
            scl_low <= 1'b0;
            sda_low <= 1'b0;
        end else begin
            unique case (st)
                E_IDLE: begin
                    if (op_valid) begin
                        kind_q  <= op_kind;
                        sda_low <= (op_kind == OP_TX) && !op_bit;
                        dly_cnt <= '0;
                        st      <= E_SETUP;
                    end
                end
                E_SETUP: begin
                    if (dly_end) begin
                        scl_low <= 1'b0;
                        str_cnt <= '0;
                        st      <= E_STRETCH;
                    end else begin
                        dly_cnt <= dly_cnt + 1'b1;
                    end
                end
                E_STRETCH: begin
                    if (stretch_end) begin
                        dly_cnt <= '0;
                        st      <= (kind_q == OP_PARK) ? E_IDLE : E_HOLD;
                    end else begin
                        str_cnt <= str_cnt + 1'b1;
                    end
                end
                E_HOLD: begin
                    if (dly_end) begin
                        dly_cnt <= '0;
                        if (kind_q == OP_START) begin
                            sda_low <= 1'b1;
                            st      <= E_SDALOW;
                        end else begin
                            scl_low <= 1'b1;
                            st      <= E_IDLE;
                        end
                    end else begin
                        dly_cnt <= dly_cnt + 1'b1;
                    end
                end
                E_SDALOW: begin
                    if (dly_end) begin
                        scl_low <= 1'b1;
                        st      <= E_IDLE;
                    end else begin
                        dly_cnt <= dly_cnt + 1'b1;
                    end
                end
                default: st <= E_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/i2cw_sequencer.sv
// Turns a latched command into a script of segments and feeds the bit
// engine one operation at a time until the park operation completes.
// Assumes: start only when idle; nbits already clamped to 0..8.
module i2cw_sequencer
    import i2cw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  wedge_mode_e       mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] regv,
    input  logic [CNT_W-1:0]  nbits,
    input  logic              op_done,
    output logic              op_valid,
    output line_op_e          op_kind,
    output logic              op_bit
);

    typedef enum logic [1:0] {Q_IDLE, Q_ISSUE, Q_WAIT} seq_st_e;

    seq_st_e           st;
    wedge_mode_e       mode_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] reg_q;
    logic [CNT_W-1:0]  n_q;
    logic [SEG_IDX_W-1:0] seg_idx;
    logic [CNT_W-1:0]  bit_idx;
    seg_t              tbl [SEG_SLOTS];
    seg_t              cur;
    logic [BYTE_W-1:0] shifted;
    logic [BYTE_W-1:0] addr_wr;
    logic [BYTE_W-1:0] addr_rd;

    // Build the hang script for the latched mode.
    always_comb begin
        addr_wr = {addr_q, 1'b0};
        addr_rd = {addr_q, 1'b1};
        for (int i = 0; i < SEG_SLOTS; i++) begin
            tbl[i] = '{kind: OP_PARK, data: '0, count: CNT_W'(1)};
        end
        unique case (mode_q)
            MODE_ACK: begin
                tbl[0] = '{kind: OP_START, data: '0,      count: CNT_W'(1)};
                tbl[1] = '{kind: OP_TX,    data: addr_wr, count: CNT_W'(8)};
            end
            MODE_READ: begin
                tbl[0] = '{kind: OP_START, data: '0,      count: CNT_W'(1)};
                tbl[1] = '{kind: OP_TX,    data: addr_wr, count: CNT_W'(8)};
                tbl[2] = '{kind: OP_RX,    data: '0,      count: CNT_W'(1)};
                tbl[3] = '{kind: OP_TX,    data: reg_q,   count: CNT_W'(8)};
                tbl[4] = '{kind: OP_RX,    data: '0,      count: CNT_W'(1)};
                tbl[5] = '{kind: OP_START, data: '0,      count: CNT_W'(1)};
                tbl[6] = '{kind: OP_TX,    data: addr_rd, count: CNT_W'(8)};
                tbl[7] = '{kind: OP_RX,    data: '0,      count: CNT_W'(1)};
                tbl[8] = '{kind: OP_RX,    data: '0,      count: n_q};
            end
            MODE_WRITE: begin
                tbl[0] = '{kind: OP_START, data: '0,      count: CNT_W'(1)};
                tbl[1] = '{kind: OP_TX,    data: addr_wr, count: CNT_W'(8)};
                tbl[2] = '{kind: OP_RX,    data: '0,      count: CNT_W'(1)};
                tbl[3] = '{kind: OP_TX,    data: reg_q,   count: n_q};
            end
            default: ;
        endcase
    end

    // Select the current segment and the bit it sends, MSB first.
    always_comb begin
        cur      = tbl[seg_idx];
        shifted  = cur.data << bit_idx;
        op_kind  = cur.kind;
        op_bit   = shifted[BYTE_W-1];
        op_valid = (st == Q_ISSUE) && (cur.count != '0);
    end

    // Walk through segments and bits, one engine operation at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= Q_IDLE;
            mode_q  <= MODE_NONE;
            addr_q  <= '0;
            reg_q   <= '0;
            n_q     <= '0;
            seg_idx <= '0;
            bit_idx <= '0;
        end else begin
            unique case (st)
                Q_IDLE: begin
                    if (start) begin
                        mode_q  <= mode;
                        addr_q  <= addr;
                        reg_q   <= regv;
                        n_q     <= nbits;
                        seg_idx <= '0;
                        bit_idx <= '0;
                        st      <= Q_ISSUE;
                    end
                end
                Q_ISSUE: begin
                    if (cur.count == '0) begin
                        seg_idx <= seg_idx + 1'b1;
                    end else begin
                        st <= Q_WAIT;
                    end
                end
                Q_WAIT: begin
                    if (op_done) begin
                        if (cur.kind == OP_PARK) begin
                            st <= Q_IDLE;
                        end else if (bit_idx + 1'b1 == cur.count) begin
                            bit_idx <= '0;
                            seg_idx <= seg_idx + 1'b1;
                            st      <= Q_ISSUE;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            st      <= Q_ISSUE;
                        end
                    end
                end
                default: st <= Q_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/i2c_wedge_gen.sv
// Top of the wedge fault injector: accepts a command, runs the partial
// transaction through the sequencer and bit engine, reports the parked
// line levels and holds the parked state until unpark.
// Assumes: open-drain pins with external pull-ups; lines sensed on scl_i/sda_i.
module i2c_wedge_gen
    import i2cw_pkg::*;
#(
    parameter int DELAY       = 8,
    parameter int STRETCH_MAX = 5000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_mode,
    input  logic [6:0] cmd_addr,
    input  logic [7:0] cmd_reg,
    input  logic [3:0] cmd_bits,
    input  logic       unpark,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       busy,
    output logic       done,
    output logic       sda_level,
    output logic       scl_level,
    output logic       stretch_timeout
);

    typedef enum logic [1:0] {T_IDLE, T_RUN, T_PARKED} top_st_e;

    top_st_e        st;
    wedge_mode_e    mode_in;
    logic           accept;
    logic [CNT_W-1:0] nbits_cl;
    logic           scl_s, sda_s;
    logic           op_valid, op_bit, op_done, park_done, stretch_expired;
    logic           eng_ready;
    line_op_e       op_kind;
    logic           to_acc;

    // Decode and clamp the incoming command.
    always_comb begin
        mode_in  = wedge_mode_e'(cmd_mode);
        accept   = (st == T_IDLE) && cmd_valid && (mode_in != MODE_NONE);
        nbits_cl = (cmd_bits > CNT_W'(BITS_MAX)) ? CNT_W'(BITS_MAX) : cmd_bits;
    end

    i2cw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .scl_s (scl_s),
        .sda_s (sda_s)
    );

    i2cw_sequencer u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .mode     (mode_in),
        .addr     (cmd_addr),
        .regv     (cmd_reg),
        .nbits    (nbits_cl),
        .op_done  (op_done),
        .op_valid (op_valid),
        .op_kind  (op_kind),
        .op_bit   (op_bit)
    );

    i2cw_bit_engine #(.DELAY(DELAY), .STRETCH_MAX(STRETCH_MAX)) u_eng (
        .clk             (clk),
        .rst_n           (rst_n),
        .op_valid        (op_valid && eng_ready),
        .op_kind         (op_kind),
        .op_bit          (op_bit),
        .scl_s           (scl_s),
        .sda_s           (sda_s),
        .ready           (eng_ready),
        .op_done         (op_done),
        .park_done       (park_done),
        .stretch_expired (stretch_expired),
        .scl_low         (scl_oe),
        .sda_low         (sda_oe)
    );

    // Transaction state, done pulse and captured park report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st              <= T_IDLE;
            busy            <= 1'b0;
            done            <= 1'b0;
            sda_level       <= 1'b1;
            scl_level       <= 1'b1;
            stretch_timeout <= 1'b0;
            to_acc          <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                T_IDLE: begin
                    if (accept) begin
                        busy   <= 1'b1;
                        to_acc <= 1'b0;
                        st     <= T_RUN;
                    end
                end
                T_RUN: begin
                    if (stretch_expired) to_acc <= 1'b1;
                    if (park_done) begin
                        busy            <= 1'b0;
                        done            <= 1'b1;
                        sda_level       <= sda_s;
                        scl_level       <= scl_s;
                        stretch_timeout <= to_acc || stretch_expired;
                        st              <= T_PARKED;
                    end
                end
                T_PARKED: begin
                    if (unpark) st <= T_IDLE;
                end
                default: st <= T_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/i2cw_checker.sv
// Temporal checks on the wedge injector's ports, attached by bind.
// Assumes: synchronous active-low reset on clk.
module i2cw_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [1:0] cmd_mode,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       busy,
    input logic       done
);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R1
    busy_from_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid && (cmd_mode != 2'b00)));

    // R10
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe));

    // R8
    no_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && !$past(scl_oe)) |-> !$fell(sda_oe));

endmodule

bind i2c_wedge_gen i2cw_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_mode  (cmd_mode),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .busy      (busy),
    .done      (done)
);

// File: tb/sim_i2c_wedge_gen.sv
// Directed bench for the wedge injector: models an open-drain bus with
// bench-controlled stretch and target pull-down, logs bus events and
// compares them against sequences built from the requirements.
module sim_i2c_wedge_gen;

    localparam int CLK_PERIOD = 10;
    localparam int DLY        = 3;
    localparam int SMAX       = 60;
    localparam int SYNC       = 2;
    localparam int TOK_START  = 2;
    localparam int TOK_STOP   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_mode = '0;
    logic [6:0] cmd_addr = '0;
    logic [7:0] cmd_reg = '0;
    logic [3:0] cmd_bits = '0;
    logic unpark = 1'b0;
    logic scl_hold = 1'b0;
    logic sda_hold = 1'b0;
    logic scl_oe, sda_oe, busy, done, sda_level, scl_level, stretch_timeout;
    wire  scl_line = !(scl_oe || scl_hold);
    wire  sda_line = !(sda_oe || sda_hold);

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    int log_q [64];
    int log_n = 0;
    int exp_q [64];
    int exp_n = 0;
    logic prev_scl = 1'b1;
    logic prev_sda = 1'b1;
    logic start_in_high = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_wedge_gen #(.DELAY(DLY), .STRETCH_MAX(SMAX), .SYNC_STAGES(SYNC)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
        .cmd_addr(cmd_addr), .cmd_reg(cmd_reg), .cmd_bits(cmd_bits),
        .unpark(unpark), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done),
        .sda_level(sda_level), .scl_level(scl_level),
        .stretch_timeout(stretch_timeout)
    );

    // Bus monitor: starts, stops, and one bit per SCL fall outside a start.
    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (prev_scl && scl_line) begin
            if (prev_sda && !sda_line && log_n < 64) begin
                log_q[log_n] = TOK_START; log_n = log_n + 1; start_in_high = 1'b1;
            end
            if (!prev_sda && sda_line && log_n < 64) begin
                log_q[log_n] = TOK_STOP; log_n = log_n + 1;
            end
        end
        if (prev_scl && !scl_line) begin
            if (!start_in_high && log_n < 64) begin
                log_q[log_n] = int'(prev_sda); log_n = log_n + 1;
            end
            start_in_high = 1'b0;
        end
        prev_scl = scl_line;
        prev_sda = sda_line;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        wait (cycles > 150000);
        n_fail = n_fail + 1;
        n_checks = n_checks + 1;
        $display("FAIL watchdog: actual cycles=%0d expected below 150000", cycles);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic push(input int v);
        exp_q[exp_n] = v; exp_n = exp_n + 1;
    endtask

    task automatic push_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) push(int'(b[7-i]));
    endtask

    task automatic compare_log(input string req);
        int bad = -1;
        for (int i = 0; i < exp_n && i < log_n; i++)
            if (bad < 0 && log_q[i] != exp_q[i]) bad = i;
        check(log_n == exp_n, req, log_n, exp_n);
        check(bad < 0, req, (bad < 0) ? 0 : log_q[bad], (bad < 0) ? 0 : exp_q[bad]);
        for (int i = 0; i < log_n; i++)
            if (log_q[i] == TOK_STOP) check(1'b0, "R8 stop seen", i, -1);
    endtask

    task automatic send_cmd(input logic [1:0] m, input logic [6:0] a,
                            input logic [7:0] r, input logic [3:0] n);
        @(negedge clk);
        log_n = 0; exp_n = 0;
        cmd_valid = 1'b1; cmd_mode = m; cmd_addr = a; cmd_reg = r; cmd_bits = n;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Waits for done; reports whether busy held high throughout.
    task automatic wait_done(input int limit, output bit seen, output bit busy_ok, output int waited);
        seen = 1'b0; busy_ok = 1'b1; waited = 0;
        while (!seen && waited < limit) begin
            if (done) seen = 1'b1;
            else begin
                if (!busy) busy_ok = 1'b0;
                @(negedge clk);
                waited = waited + 1;
            end
        end
    endtask

    task automatic do_unpark();
        @(negedge clk); unpark = 1'b1;
        @(negedge clk); unpark = 1'b0;
    endtask

    task automatic finish_park(input string req, input bit exp_sda);
        bit seen, bok; int w;
        wait_done(5000, seen, bok, w);
        check(seen, {req, " done"}, int'(seen), 1);
        check(bok, "R1 busy held", int'(bok), 1);
        check(!busy && !scl_oe && !sda_oe, "R6 released at done",
              int'({busy, scl_oe, sda_oe}), 0);
        check(sda_level == exp_sda && scl_level && !stretch_timeout, "R6 levels",
              int'({sda_level, scl_level, stretch_timeout}), int'({exp_sda, 2'b10}));
        @(negedge clk);
        check(!done, "R6 done single", int'(done), 0);
    endtask

    task automatic t_reset();
        check(!scl_oe && !sda_oe && !busy && !done, "R10 reset",
              int'({scl_oe, sda_oe, busy, done}), 0);
    endtask

    task automatic t_ack();
        send_cmd(2'd1, 7'h5A, 8'h00, 4'd0);
        check(busy, "R1 busy after accept", int'(busy), 1);
        finish_park("R2", 1'b1);
        push(TOK_START); push_bits({7'h5A, 1'b0}, 8);
        compare_log("R2 ack sequence");
        do_unpark();
    endtask

    task automatic t_read(input logic [6:0] a, input logic [7:0] r, input logic [3:0] n, input string req);
        int eff = (n > 8) ? 8 : int'(n);
        send_cmd(2'd2, a, r, n);
        finish_park(req, 1'b1);
        push(TOK_START); push_bits({a, 1'b0}, 8); push(1);
        push_bits(r, 8); push(1);
        push(TOK_START); push_bits({a, 1'b1}, 8); push(1);
        for (int i = 0; i < eff; i++) push(1);
        compare_log(req);
        do_unpark();
    endtask

    task automatic t_write(input logic [6:0] a, input logic [7:0] r, input logic [3:0] n, input string req);
        int eff = (n > 8) ? 8 : int'(n);
        send_cmd(2'd3, a, r, n);
        finish_park(req, 1'b1);
        push(TOK_START); push_bits({a, 1'b0}, 8); push(1);
        push_bits(r, eff);
        compare_log(req);
        do_unpark();
    endtask

    task automatic t_sda_low();
        send_cmd(2'd1, 7'h33, 8'h00, 4'd0);
        wait (log_n == 9);
        @(negedge clk); sda_hold = 1'b1;
        finish_park("R6 sda low", 1'b0);
        sda_hold = 1'b0;
        do_unpark();
    endtask

    task automatic t_stretch();
        bit seen, bok, early; int w;
        send_cmd(2'd1, 7'h11, 8'h00, 4'd0);
        wait (log_n == 9);
        @(negedge clk); scl_hold = 1'b1;
        early = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (done) early = 1'b1;
        end
        check(!early, "R6 no done while SCL low", int'(early), 0);
        scl_hold = 1'b0;
        wait_done(SYNC + 3, seen, bok, w);
        check(seen, "R6 done after SCL high", w, SYNC + 1);
        check(scl_level && sda_level && !stretch_timeout, "R7 no timeout",
              int'({scl_level, sda_level, stretch_timeout}), 6);
        do_unpark();
    endtask

    task automatic t_timeout();
        bit seen, bok; int w;
        send_cmd(2'd1, 7'h22, 8'h00, 4'd0);
        wait (log_n == 9);
        @(negedge clk); scl_hold = 1'b1;
        wait_done(SMAX * 4, seen, bok, w);
        check(seen && w >= SMAX, "R7 timeout delay", w, SMAX);
        check(stretch_timeout && !scl_level, "R7 timeout report",
              int'({stretch_timeout, scl_level}), 2);
        scl_hold = 1'b0;
        do_unpark();
    endtask

    task automatic t_ignore();
        bit moved = 1'b0;
        send_cmd(2'd0, 7'h44, 8'hFF, 4'd8);
        for (int i = 0; i < 12; i++) begin
            if (busy || scl_oe || sda_oe) moved = 1'b1;
            @(negedge clk);
        end
        check(!moved, "R1 mode 0 ignored", int'(moved), 0);
    endtask

    task automatic t_park_hold();
        bit moved = 1'b0;
        bit seen, bok; int w;
        send_cmd(2'd1, 7'h0F, 8'h00, 4'd0);
        wait_done(5000, seen, bok, w);
        @(negedge clk);
        send_cmd(2'd3, 7'h0F, 8'hAA, 4'd4);
        for (int i = 0; i < 12; i++) begin
            if (busy || scl_oe || sda_oe) moved = 1'b1;
            @(negedge clk);
        end
        check(!moved, "R9 command ignored while parked", int'(moved), 0);
        do_unpark();
        send_cmd(2'd3, 7'h0F, 8'hAA, 4'd4);
        check(busy, "R9 accepted after unpark", int'(busy), 1);
        finish_park("R9", 1'b1);
        do_unpark();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ack();
        t_read(7'h21, 8'hC5, 4'd3, "R3 read n=3");
        t_read(7'h6E, 8'h3C, 4'd12, "R5 read clamp");
        t_write(7'h48, 8'hB6, 4'd5, "R4 write n=5");
        t_write(7'h48, 8'h81, 4'd0, "R5 write n=0");
        t_write(7'h07, 8'h5D, 4'd15, "R5 write clamp");
        t_sda_low();
        t_stretch();
        t_timeout();
        t_ignore();
        t_park_hold();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule